// File: doc/BRIEF.md
# Programmable Wordline Pulse Timer

This block drives the wordline enable of a single memory subarray. An access strobe raises the wordline at once. The falling edge is held back by a chain of unit-delay stages, each lasting one clock tick. A stored binary code selects how many of those stages take part. Narrowing the pulse lowers array switching energy on subarrays whose weakest cells still read correctly with a shorter window.

A test controller writes the code through a one-cycle load strobe. The block keeps that code in its own register, one per subarray, and reports it back. Reset installs the largest code, which gives the widest and safest pulse. A floor on the stage count keeps the shortest pulse at a fixed minimum, so hold timing can be closed against a known bound.

The stage mask for each pulse is taken when the pulse starts. Code writes and extra strobes that arrive during a pulse cannot change the pulse already running.

Top module: `wl_pulse_timer`

## Requirements
- R1: While reset is asserted and right after it, `wl_en` and `busy` are 0 and `code_q` holds all ones (the largest code).
- R2: A clock edge with `code_wr` high stores `code_din` in the code register, and the new value shows on `code_q` after that edge. With `code_wr` low, `code_q` does not change.
- R3: When `acc_stb` is high at a clock edge and no pulse is active, `wl_en` goes high at that same edge.
- R4: The code is read as an unsigned binary number c. The pulse stays high for max(c + 1, MIN_W) clock cycles and then falls.
- R5: The pulse width comes from the code held in the register at the edge where the pulse starts. If `code_wr` and `acc_stb` are both high at that edge, the pulse uses the previously stored code, and the new code applies from the next access on.
- R6: A code load during an active pulse leaves that pulse's width unchanged. The next access uses the new code.
- R7: An `acc_stb` during an active pulse (including the edge where the pulse ends) is ignored: it neither extends nor restarts the pulse. A strobe held high therefore gives back-to-back pulses separated by exactly one low cycle.
- R8: `busy` is high in exactly the cycles in which `wl_en` is high.
- R9: Codes below MIN_W - 1 are clamped. With the default MIN_W = 2, codes 0 and 1 both give a 2-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay stage per period |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Access strobe that opens the wordline |
| code_wr | input | 1 | Load strobe for the stored width code |
| code_din | input | CODE_W | Width code to store |
| wl_en | output | 1 | Wordline enable pulse |
| busy | output | 1 | High while a pulse is in progress |
| code_q | output | CODE_W | Currently stored width code |

## Verification
Two kinds of events can land in the same cycle: a code load and the start of a pulse, and a code load or a new strobe partway through a pulse. The bench drives `code_wr` and `acc_stb` together at one edge. It expects the resulting pulse to have the width of the old code and the following pulse to have the width of the new code. It also writes a code and pulses the strobe in the middle of a long pulse. The width, counted at the pins on falling clock edges, must stay at the value of the code taken at the start.

// File: rtl/wlpt_pkg.sv
package wlpt_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HOLD = 1'b1
  } phase_e;

  // Pulse length in ticks for a binary code with a floor of min_w ticks.
  function automatic int unsigned pulse_ticks(int unsigned code, int unsigned min_w);
    int unsigned raw;
    raw = code + 1;
    return (raw < min_w) ? min_w : raw;
  endfunction

endpackage

// File: rtl/wlpt_code_reg.sv
module wlpt_code_reg #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '1;
    else if (wr) q <= din;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(din)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));

endmodule

// File: rtl/wlpt_therm_dec.sv
module wlpt_therm_dec #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned STAGES = 7,
  parameter int unsigned MIN_W  = 2
) (
  input  logic [CODE_W-1:0] code,
  output logic [STAGES-1:0] mask
);

  logic [STAGES-1:0] therm;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam logic [CODE_W-1:0] IDX = CODE_W'(i);
    localparam bit FLOOR = (i + 1 < MIN_W);
    assign therm[i] = (code > IDX);
    assign mask[i]  = therm[i] | FLOOR;
  end

  always_comb begin
    p_therm_count_r4: assert ($countones(therm) == int'(code));
    p_floor_r9: assert ($countones(mask) + 1 >= MIN_W);
  end

endmodule

// File: rtl/wlpt_delay_chain.sv
module wlpt_delay_chain
  import wlpt_pkg::*;
#(
  parameter int unsigned STAGES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STAGES-1:0] mask,
  output logic              active,
  output logic              drained
);

  phase_e            phase;
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      chain <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_HOLD;
          chain <= mask;
        end
        PH_HOLD: begin
          if (chain == '0) phase <= PH_IDLE;
          else chain <= chain >> 1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign active  = (phase == PH_HOLD);
  assign drained = (chain == '0);

  p_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !drained) |=> (active && ($countones(chain) + 1 == $countones($past(chain)))));
  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && drained) |=> !active);

endmodule

// File: rtl/wl_pulse_timer.sv
module wl_pulse_timer
  import wlpt_pkg::*;
#(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned MIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_din,
  output logic              wl_en,
  output logic              busy,
  output logic [CODE_W-1:0] code_q
);

  localparam int unsigned STAGES = (1 << CODE_W) - 1;
  localparam int unsigned CNT_W  = $clog2(STAGES + 2) + 1;

  logic [STAGES-1:0] stage_mask;
  logic              wl_active;
  logic              chain_drained;
  logic              start_acc;

  wlpt_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n), .wr(code_wr), .din(code_din), .q(code_q)
  );

  wlpt_therm_dec #(.CODE_W(CODE_W), .STAGES(STAGES), .MIN_W(MIN_W)) u_dec (
    .code(code_q), .mask(stage_mask)
  );

  assign start_acc = acc_stb & ~wl_active;

  wlpt_delay_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst_n(rst_n), .start(start_acc), .mask(stage_mask),
    .active(wl_active), .drained(chain_drained)
  );

  assign wl_en = wl_active;
  assign busy  = wl_active;

  // Observation state for the width assertion.
  logic [CODE_W-1:0] run_code;
  logic [CNT_W-1:0]  hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_code <= '1;
      hi_cnt   <= '0;
    end else if (start_acc) begin
      run_code <= code_q;
      hi_cnt   <= '0;
    end else if (wl_active) begin
      hi_cnt   <= hi_cnt + 1'b1;
    end
  end

  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !wl_en) |=> wl_en);
  p_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_en) |-> (int'(hi_cnt) == int'(pulse_ticks(int'(run_code), MIN_W))));
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_en && !chain_drained) |=> (wl_en && $stable(run_code)));

  if (MIN_W >= 2) begin : g_min
    p_min_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wl_en) |=> wl_en);
  end

endmodule

// File: tb/wl_pulse_timer_tb.sv
module wl_pulse_timer_tb;

  localparam int CW = 3;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_stb = 1'b0;
  logic code_wr = 1'b0;
  logic [CW-1:0] code_din = '0;
  logic wl_en, busy;
  logic [CW-1:0] code_q;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  wl_pulse_timer #(.CODE_W(CW), .MIN_W(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .code_wr(code_wr),
    .code_din(code_din), .wl_en(wl_en), .busy(busy), .code_q(code_q)
  );

  always #5 clk = ~clk;

  function automatic int exp_w(int c);
    return (c + 1 < MW) ? MW : c + 1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 50000", cycles);
      summary();
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic set_code(int c);
    code_wr = 1'b1; code_din = CW'(c);
    @(negedge clk);
    code_wr = 1'b0;
    chk(code_q == CW'(c), "R2 code load", int'(code_q), c);
  endtask

  // Counts high cycles from the current negedge; busy must track wl_en (R8).
  task automatic count_high(output int w);
    bit ok = 1'b1;
    w = 0;
    while (wl_en && w < 64) begin
      if (busy !== wl_en) ok = 1'b0;
      w++;
      @(negedge clk);
    end
    if (busy !== 1'b0) ok = 1'b0;
    chk(ok, "R8 busy tracks wl_en", int'(busy), int'(wl_en));
  endtask

  task automatic fire(output int w);
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    chk(wl_en === 1'b1, "R3 rise on strobe", int'(wl_en), 1);
    count_high(w);
  endtask

  initial begin
    int w, w2, lo;
    repeat (3) @(negedge clk);
    chk(wl_en === 1'b0, "R1 reset wl_en", int'(wl_en), 0);
    chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    chk(code_q === '1, "R1 reset code", int'(code_q), (1 << CW) - 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_q === '1, "R1 code after reset", int'(code_q), (1 << CW) - 1);

    fire(w);
    chk(w == exp_w((1 << CW) - 1), "R4 width with reset code", w, exp_w((1 << CW) - 1));

    // R4 / R9: sweep every code
    for (int c = 0; c < (1 << CW); c++) begin
      set_code(c);
      fire(w);
      chk(w == exp_w(c), (c < MW - 1 || c == MW - 1) ? "R9 clamped width" : "R4 width", w, exp_w(c));
    end

    // R5: load and strobe at the same edge (current code 7)
    code_wr = 1'b1; code_din = 3'd2; acc_stb = 1'b1;
    @(negedge clk);
    code_wr = 1'b0; acc_stb = 1'b0;
    count_high(w);
    chk(w == exp_w(7), "R5 same-edge uses old code", w, exp_w(7));
    chk(code_q == 3'd2, "R5 new code stored", int'(code_q), 2);
    fire(w);
    chk(w == exp_w(2), "R5 next access uses new code", w, exp_w(2));

    // R6: load mid-pulse
    set_code(7);
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    w = 1;
    @(negedge clk);
    w++;
    code_wr = 1'b1; code_din = 3'd1;
    @(negedge clk);
    code_wr = 1'b0;
    count_high(w2);
    chk(w + w2 == exp_w(7), "R6 mid-pulse load keeps width", w + w2, exp_w(7));
    fire(w);
    chk(w == exp_w(1), "R6 next access uses loaded code", w, exp_w(1));

    // R7: strobe during a pulse is ignored
    set_code(4);
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    w = 1;
    @(negedge clk);
    w++;
    acc_stb = 1'b1;
    @(negedge clk);
    acc_stb = 1'b0;
    count_high(w2);
    chk(w + w2 == exp_w(4), "R7 strobe mid-pulse no extension", w + w2, exp_w(4));
    @(negedge clk);
    chk(wl_en === 1'b0, "R7 no restart after ignored strobe", int'(wl_en), 0);

    // R7: held strobe gives one low cycle between pulses
    set_code(2);
    acc_stb = 1'b1;
    @(negedge clk);
    count_high(w);
    lo = 0;
    while (!wl_en && lo < 16) begin lo++; @(negedge clk); end
    acc_stb = 1'b0;
    count_high(w2);
    chk(w == exp_w(2), "R7 held strobe first pulse", w, exp_w(2));
    chk(lo == 1, "R7 held strobe gap", lo, 1);
    chk(w2 == exp_w(2), "R7 held strobe second pulse", w2, exp_w(2));

    summary();
  end

endmodule